// File: doc/BRIEF.md
# UART FIFO Level and Receive-Timeout Interrupt Controller

This block turns the fill levels of a UART's receive and transmit queues, the transmit-queue empty flag and the receive-timeout flag into interrupt requests. Two of the four sources compare a queue occupancy against a programmable trip point. The receive and transmit occupancy widths come from independent depth parameters. The transmit-empty source is a level that follows its flag. The receive-timeout source is sticky: it is captured by a small state machine and is cleared by software with a write-one-to-clear strobe.

Every source has its own enable bit. The raw status vector reports active sources whether or not they are enabled, so software can poll it. The masked requests come out one per source. A single composite interrupt line is registered, so it follows the OR of the enabled active sources one clock later.

Status and request bit order, used by every vector port: bit 0 is receive timeout, bit 1 is receive level reached, bit 2 is transmit level low, and bit 3 is transmit empty.

The timeout state machine has three states:
- TO_IDLE: nothing is pending. TO_IDLE goes to TO_PEND when the timeout flag is high.
- TO_PEND: the status bit is set. TO_PEND goes to TO_IDLE on a clear while the flag is low, and to TO_REARM on a clear while the flag is still high.
- TO_REARM: the bit was cleared but the flag has not yet dropped. TO_REARM goes to TO_IDLE once the flag is low.

The composite output has two states. IRQ_QUIET goes to IRQ_RAISED when any masked request is active. IRQ_RAISED goes back to IRQ_QUIET when none is.

Top module: `uart_fifo_irq`

## Requirements
- R1: While reset is held and in the first cycle after it, status bit 0 and `irq` are 0.
- R2: Status bit 1 is 1 in the same cycle that `rx_count` is greater than or equal to `rx_level`, and 0 otherwise, including a trip point of 0.
- R3: Status bit 2 is 1 in the same cycle that `tx_count` is less than or equal to `tx_level`, and 0 otherwise.
- R4: Status bit 3 equals `tx_empty` in the same cycle.
- R5: Status bit 0 becomes 1 on the clock edge after `rto_flag` is sampled high in TO_IDLE. It then stays 1 after `rto_flag` falls, until it is cleared.
- R6: A cycle with `sts_wr` high and `sts_wdata[0]` = 1 clears status bit 0 at that edge. A write with `sts_wdata[0]` = 0 leaves status bit 0 at 1. Writes never change bits 1 to 3.
- R7: If the clear lands while `rto_flag` is still high, status bit 0 stays 0 until `rto_flag` has been low for at least one edge and is then high again.
- R8: When `rto_flag` is high in TO_IDLE, a clear in the same cycle does not stop status bit 0 from being set.
- R9: `int_req` equals the status vector ANDed bit by bit with `int_en`. The status vector itself does not depend on `int_en`.
- R10: `irq` at each edge takes the OR of `int_req` from the cycle before. It rises one cycle after a request appears and falls one cycle after the last one goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | RX_CW | Receive queue occupancy |
| tx_count | input | TX_CW | Transmit queue occupancy |
| tx_empty | input | 1 | Transmit queue empty flag |
| rto_flag | input | 1 | Receive timeout flag |
| int_en | input | 4 | Per-source enable, in status bit order |
| rx_level | input | RX_CW | Receive trip point (at or above) |
| tx_level | input | TX_CW | Transmit trip point (at or below) |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Status write data; a 1 in bit 0 clears the timeout |
| int_status | output | 4 | Raw active sources |
| int_req | output | 4 | Enabled active sources |
| irq | output | 1 | Registered composite interrupt |

## Verification
The level sources are driven across their trip points. The bench uses the values just below, at and above the threshold, and a trip point of zero. This shows whether each compare uses its intended inclusive direction or is off by one.

The timeout source is driven in three ways:
- set, then released, then cleared, which separates a sticky bit from a level bit;
- cleared while the flag is still high, which shows whether the bit re-arms too early;
- set and cleared in the same cycle, which shows which of the two wins.

The mask tests toggle each enable while its source is active. They sample `irq` before and after the edge, which exposes a composite line that is combinational instead of registered.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC = 4;

    // status vector bit positions
    localparam int SRC_RTO  = 0;
    localparam int SRC_RXHI = 1;
    localparam int SRC_TXLO = 2;
    localparam int SRC_TXE  = 3;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_PEND  = 2'd1,
        TO_REARM = 2'd2
    } rto_state_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int W       = 7,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] level,
    output logic         hit
);
    generate
        if (AT_LEAST) begin : g_ge
            assign hit = (count >= level);
        end else begin : g_le
            assign hit = (count <= level);
        end
    endgenerate
endmodule

// File: rtl/irq_rto_fsm.sv
module irq_rto_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic clr,
    output logic pending
);
    rto_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TO_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TO_IDLE:  if (flag) state_d = TO_PEND;
            TO_PEND:  if (clr)  state_d = flag ? TO_REARM : TO_IDLE;
            TO_REARM: if (!flag) state_d = TO_IDLE;
            default:  state_d = TO_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == TO_PEND);
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import uart_irq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic         irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (|req)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (~|req) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_irq_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    localparam int RX_CW   = $clog2(RX_DEPTH + 1),
    localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RX_CW-1:0] rx_count,
    input  logic [TX_CW-1:0] tx_count,
    input  logic             tx_empty,
    input  logic             rto_flag,
    input  logic [3:0]       int_en,
    input  logic [RX_CW-1:0] rx_level,
    input  logic [TX_CW-1:0] tx_level,
    input  logic             sts_wr,
    input  logic [3:0]       sts_wdata,
    output logic [3:0]       int_status,
    output logic [3:0]       int_req,
    output logic             irq
);
    logic rx_hit, tx_hit, rto_pend, rto_clr;

    assign rto_clr = sts_wr & sts_wdata[SRC_RTO];

    irq_level_cmp #(.W(RX_CW), .AT_LEAST(1'b1)) u_rx_cmp (
        .count (rx_count),
        .level (rx_level),
        .hit   (rx_hit)
    );

    irq_level_cmp #(.W(TX_CW), .AT_LEAST(1'b0)) u_tx_cmp (
        .count (tx_count),
        .level (tx_level),
        .hit   (tx_hit)
    );

    irq_rto_fsm u_rto (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag    (rto_flag),
        .clr     (rto_clr),
        .pending (rto_pend)
    );

    always_comb begin
        int_status           = '0;
        int_status[SRC_RTO]  = rto_pend;
        int_status[SRC_RXHI] = rx_hit;
        int_status[SRC_TXLO] = tx_hit;
        int_status[SRC_TXE]  = tx_empty;
    end

    assign int_req = int_status & int_en;

    irq_merge #(.N(NSRC)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (int_req),
        .irq   (irq)
    );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_empty,
    input logic       rto_flag,
    input logic [3:0] int_en,
    input logic       sts_wr,
    input logic [3:0] sts_wdata,
    input logic [3:0] int_status,
    input logic [3:0] int_req,
    input logic       irq
);
    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req == (int_status & int_en));

    assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == (|$past(int_req))));

    assert_rto_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[0]) |-> $past(rto_flag));

    assert_rto_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[0] && !(sts_wr && sts_wdata[0])) |=> int_status[0]);

    assert_rto_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[0] && sts_wr && sts_wdata[0]) |=> !int_status[0]);

    assert_tx_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_status[3] == tx_empty);
endmodule

bind uart_fifo_irq uart_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_empty   (tx_empty),
    .rto_flag   (rto_flag),
    .int_en     (int_en),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .int_status (int_status),
    .int_req    (int_req),
    .irq        (irq)
);

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0, rx_level = '0, tx_level = '0;
    logic          tx_empty = 1'b0, rto_flag = 1'b0, sts_wr = 1'b0;
    logic [3:0]    int_en = '0, sts_wdata = '0;
    logic [3:0]    int_status, int_req;
    logic          irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .tx_empty(tx_empty), .rto_flag(rto_flag), .int_en(int_en),
        .rx_level(rx_level), .tx_level(tx_level), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .int_status(int_status), .int_req(int_req),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_rto(logic [3:0] data);
        sts_wr = 1'b1; sts_wdata = data;
        step();
        sts_wr = 1'b0; sts_wdata = '0;
    endtask

    task automatic t_reset();
        rx_level = 7'd32; tx_level = 7'd16; tx_count = 7'd64;
        rto_flag = 1'b1;
        repeat (3) step();
        check("R1 status in reset", int_status, 4'b0000);
        check("R1 irq in reset", irq, 1'b0);
        rto_flag = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1 status after reset", int_status[0], 1'b0);
        check("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_rx_level();
        rx_level = 7'd32;
        rx_count = 7'd31; #1 check("R2 below", int_status[1], 1'b0);
        rx_count = 7'd32; #1 check("R2 equal", int_status[1], 1'b1);
        rx_count = 7'd64; #1 check("R2 full", int_status[1], 1'b1);
        rx_level = 7'd0; rx_count = 7'd0; #1 check("R2 zero level", int_status[1], 1'b1);
        rx_level = 7'd32; rx_count = 7'd0; #1;
        step();
    endtask

    task automatic t_tx_level();
        tx_level = 7'd16;
        tx_count = 7'd17; #1 check("R3 above", int_status[2], 1'b0);
        tx_count = 7'd16; #1 check("R3 equal", int_status[2], 1'b1);
        tx_count = 7'd0;  #1 check("R3 zero", int_status[2], 1'b1);
        tx_count = 7'd64; #1;
        step();
    endtask

    task automatic t_tx_empty();
        tx_empty = 1'b1; #1 check("R4 empty set", int_status[3], 1'b1);
        tx_empty = 1'b0; #1 check("R4 empty clear", int_status[3], 1'b0);
        step();
    endtask

    task automatic t_rto_basic();
        rto_flag = 1'b1; #1 check("R5 not yet", int_status[0], 1'b0);
        step();
        check("R5 set", int_status[0], 1'b1);
        rto_flag = 1'b0;
        repeat (3) step();
        check("R5 sticky", int_status[0], 1'b1);
        clear_rto(4'b1110);
        check("R6 zero bit ignored", int_status[0], 1'b1);
        check("R6 level bits untouched", int_status[3:1], 3'b000);
        clear_rto(4'b0001);
        check("R6 cleared", int_status[0], 1'b0);
    endtask

    task automatic t_rto_rearm();
        rto_flag = 1'b1;
        step();
        check("R7 set", int_status[0], 1'b1);
        clear_rto(4'b0001);
        check("R7 cleared while high", int_status[0], 1'b0);
        repeat (3) step();
        check("R7 no early rearm", int_status[0], 1'b0);
        rto_flag = 1'b0;
        step();
        check("R7 still clear", int_status[0], 1'b0);
        rto_flag = 1'b1;
        step();
        step();
        check("R7 rearmed", int_status[0], 1'b1);
        rto_flag = 1'b0;
        clear_rto(4'b0001);
        check("R7 final clear", int_status[0], 1'b0);
    endtask

    task automatic t_set_wins();
        rto_flag = 1'b1; sts_wr = 1'b1; sts_wdata = 4'b0001;
        step();
        sts_wr = 1'b0; sts_wdata = '0; rto_flag = 1'b0;
        check("R8 set beats clear", int_status[0], 1'b1);
        clear_rto(4'b0001);
        check("R8 cleanup", int_status[0], 1'b0);
    endtask

    task automatic t_mask();
        int_en = 4'b0000; tx_empty = 1'b1; #1;
        check("R9 status unmasked", int_status[3], 1'b1);
        check("R9 req masked", int_req, 4'b0000);
        step();
        check("R10 no irq when masked", irq, 1'b0);
        int_en = 4'b1000; #1;
        check("R9 req enabled", int_req, 4'b1000);
        check("R10 irq not combinational", irq, 1'b0);
        step();
        check("R10 irq raised", irq, 1'b1);
        tx_empty = 1'b0; #1;
        check("R10 irq held until edge", irq, 1'b1);
        step();
        check("R10 irq dropped", irq, 1'b0);
        rx_level = 7'd4; rx_count = 7'd8; int_en = 4'b0010; #1;
        check("R9 rx req", int_req, 4'b0010);
        step();
        check("R10 irq rx", irq, 1'b1);
        int_en = 4'b0000;
        step();
        check("R10 irq off by enable", irq, 1'b0);
        rx_count = 7'd0;
    endtask

    initial begin
        t_reset();
        t_rx_level();
        t_tx_level();
        t_tx_empty();
        t_rto_basic();
        t_rto_rearm();
        t_set_wins();
        t_mask();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule